// File: doc/BRIEF.md
# Dual-Sign-Bit Add/Subtract Unit with Status Flags

This unit adds or subtracts two two's-complement operands of configurable width in a single combinational pass. Each operand is carried one bit wider than its natural width, with its sign copied into that extra position. The two top bits of the widened sum then show whether the result fits. If it does not, they also show which way it left the range. The result, a positive-overflow line and a negative-overflow line are available in the same cycle as the operands.

A second overflow indication is formed at the same time from the carries into and out of the sign position. The two methods are checked against each other. Five status conditions are produced:

- zero
- carry on add, or borrow on subtract
- overflow
- sign
- even parity

They are loaded into a status register on the clock edge at which the write enable is high. Between writes the register keeps its value.

Top module: `dsb_alu`

## Requirements
- R1: `sum_o` equals `a_i + b_i` modulo 2^WIDTH when `sub_i` is 0, and `a_i - b_i` modulo 2^WIDTH when `sub_i` is 1. Subtraction is formed by inverting every bit of `b_i` and injecting a carry of 1.
- R2: `ovf_pos_o` is 1 exactly when the signed result is larger than 2^(WIDTH-1)-1. In that case the two widened sign bits read 01.
- R3: `ovf_neg_o` is 1 exactly when the signed result is smaller than -2^(WIDTH-1). In that case the two widened sign bits read 10.
- R4: `ovf_o` is the OR of `ovf_pos_o` and `ovf_neg_o`, and it always equals the XOR of the carry into and the carry out of the sign bit.
- R5: Adding operands with different signs, or subtracting operands with the same sign, never sets any overflow output.
- R6: Flag bit 0 (zero) is 1 when every bit of the result is 0.
- R7: Flag bit 1 (carry/borrow) is 1 on an unsigned carry out of an add. On a subtract it is 1 when unsigned `a_i` is less than unsigned `b_i`.
- R8: Flag bit 2 is the overflow flag (R4), and flag bit 3 (sign) copies the most significant bit of the result.
- R9: Flag bit 4 (parity) is 1 when the result holds an even number of 1 bits.
- R10: `flags_o` is 0 during reset. It loads the flags of the current operation on a rising clock edge when `flag_we_i` is 1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the status register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| flag_we_i | input | 1 | Loads the status register on the next edge |
| sum_o | output | WIDTH | Result, combinational |
| ovf_pos_o | output | 1 | Positive overflow, combinational |
| ovf_neg_o | output | 1 | Negative overflow, combinational |
| ovf_o | output | 1 | Either overflow, combinational |
| flags_o | output | 5 | Registered flags {parity, sign, overflow, carry, zero} |

## Verification
The hardest corner to reach is subtracting the most negative value. Its negation does not fit in WIDTH bits, so the extra sign bit alone decides the overflow direction. The stimulus therefore pairs the extreme codes directly: 0 minus the minimum, the minimum minus 1, and the minimum minus -1. It also covers sums that wrap to zero while producing a carry. Between those operations, writes with the enable low confirm that the registered flags keep the earlier capture.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int NFLAGS = 5;
  // bit order: zer=0 cry=1 ovf=2 sgn=3 par=4
  typedef struct packed {
    logic par;
    logic sgn;
    logic ovf;
    logic cry;
    logic zer;
  } flags_t;
endpackage

// File: rtl/dsb_operand_ext.sv
module dsb_operand_ext #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH:0]   xa_o,
  output logic [WIDTH:0]   xb_o,
  output logic             cin_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] xb_raw;

  assign xa_o   = {a_i[MSB], a_i};
  assign xb_raw = {b_i[MSB], b_i};
  // invert both sign copies and all data bits on subtract
  assign xb_o   = sub_i ? ~xb_raw : xb_raw;
  assign cin_o  = sub_i;
endmodule

// File: rtl/dsb_adder.sv
module dsb_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   xa_i,
  input  logic [WIDTH:0]   xb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [1:0]       sgn2_o,
  output logic             cout_o,
  output logic             xovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH+1:0] wide;
  logic [WIDTH:0]   unsig;
  logic [MSB:0]     low;

  assign wide   = {1'b0, xa_i} + {1'b0, xb_i} + {{(WIDTH+1){1'b0}}, cin_i};
  assign sum_o  = wide[MSB:0];
  assign sgn2_o = wide[WIDTH:MSB];

  // carry out of the sign position
  assign unsig  = {1'b0, xa_i[MSB:0]} + {1'b0, xb_i[MSB:0]} + {{WIDTH{1'b0}}, cin_i};
  assign cout_o = unsig[WIDTH];

  // carry into the sign position
  assign low    = {1'b0, xa_i[MSB-1:0]} + {1'b0, xb_i[MSB-1:0]} + {{MSB{1'b0}}, cin_i};
  assign xovf_o = low[MSB] ^ unsig[WIDTH];
endmodule

// File: rtl/dsb_flag_gen.sv
module dsb_flag_gen
  import dsb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic [1:0]       sgn2_i,
  input  logic             cout_i,
  input  logic             sub_i,
  output logic             pos_o,
  output logic             neg_o,
  output flags_t           flags_o
);
  assign pos_o = (sgn2_i == 2'b01);
  assign neg_o = (sgn2_i == 2'b10);

  always_comb begin
    flags_o     = '0;
    flags_o.zer = (sum_i == '0);
    flags_o.cry = sub_i ? ~cout_i : cout_i;
    flags_o.ovf = pos_o | neg_o;
    flags_o.sgn = sum_i[WIDTH-1];
    flags_o.par = ~(^sum_i);
  end
endmodule

// File: rtl/dsb_alu.sv
module dsb_alu
  import dsb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic              sub_i,
  input  logic              flag_we_i,
  output logic [WIDTH-1:0]  sum_o,
  output logic              ovf_pos_o,
  output logic              ovf_neg_o,
  output logic              ovf_o,
  output logic [NFLAGS-1:0] flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] xa, xb;
  logic           cin, cout, xovf;
  logic [1:0]     sgn2;
  flags_t         live, flags_q;

  dsb_operand_ext #(.WIDTH(WIDTH)) u_ext (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .xa_o(xa), .xb_o(xb), .cin_o(cin)
  );

  dsb_adder #(.WIDTH(WIDTH)) u_add (
    .xa_i(xa), .xb_i(xb), .cin_i(cin),
    .sum_o(sum_o), .sgn2_o(sgn2), .cout_o(cout), .xovf_o(xovf)
  );

  dsb_flag_gen #(.WIDTH(WIDTH)) u_flg (
    .sum_i(sum_o), .sgn2_i(sgn2), .cout_i(cout), .sub_i(sub_i),
    .pos_o(ovf_pos_o), .neg_o(ovf_neg_o), .flags_o(live)
  );

  assign ovf_o = live.ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= '0;
    else if (flag_we_i) flags_q <= live;
  end

  assign flags_o = flags_q;

  assert_ovf_methods_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o == xovf);

  assert_ovf_dir_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_pos_o, ovf_neg_o}));

  assert_no_mixed_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_i[MSB] ^ b_i[MSB]) ^ sub_i) |-> !(ovf_pos_o || ovf_neg_o));

  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  assert_flag_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(live));
endmodule

// File: tb/sim_dsb_alu.sv
module sim_dsb_alu;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] sum;
    logic         pos;
    logic         neg;
    logic [4:0]   flg;
  } exp_t;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] a = '0, b = '0;
  logic         sub = 0, we = 0;
  logic [W-1:0] sum;
  logic         pos, neg, ovf;
  logic [4:0]   flags;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  logic [4:0] reg_model = '0;
  bit done = 0;

  dsb_alu #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sub_i(sub),
    .flag_we_i(we), .sum_o(sum), .ovf_pos_o(pos), .ovf_neg_o(neg),
    .ovf_o(ovf), .flags_o(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int sa, int sb, bit s, bit w);
    exp_t e;
    int tv, ua, ub;
    logic [4:0] f;
    @(negedge clk);
    a = sa[W-1:0]; b = sb[W-1:0]; sub = s; we = w;
    ua = int'(a); ub = int'(b);
    tv = s ? sa - sb : sa + sb;
    e.sum = tv[W-1:0];
    e.pos = tv > (2**(W-1) - 1);
    e.neg = tv < -(2**(W-1));
    f[0] = (e.sum == 0);
    f[1] = s ? (ua < ub) : (ua + ub >= 2**W);
    f[2] = e.pos | e.neg;
    f[3] = e.sum[W-1];
    f[4] = ($countones(e.sum) % 2 == 0);
    if (w) reg_model = f;
    e.flg = reg_model;
    q.push_back(e);
  endtask

  // monitor: after the edge that follows each drive
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R1 sum", 32'(sum), 32'(e.sum));
      check("R2 pos ovf", 32'(pos), 32'(e.pos));
      check("R3 neg ovf", 32'(neg), 32'(e.neg));
      check("R4 ovf or", 32'(ovf), 32'(e.pos | e.neg));
      check("R6 zero", 32'(flags[0]), 32'(e.flg[0]));
      check("R7 carry", 32'(flags[1]), 32'(e.flg[1]));
      check("R8 ovf/sign", 32'(flags[3:2]), 32'(e.flg[3:2]));
      check("R9 parity", 32'(flags[4]), 32'(e.flg[4]));
      check("R10 reg", 32'(flags), 32'(e.flg));
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    we = 1; a = 8'hff; b = 8'h01;
    repeat (2) @(posedge clk);
    #1 check("R10 reset", 32'(flags), 0);
    @(negedge clk) rst_n = 1; we = 0;
    drive(100, 100, 0, 1);   // R2
    drive(-100, -100, 0, 1); // R3
    drive(127, 1, 0, 1);     // R2
    drive(-128, -1, 0, 1);   // R3 with carry
    drive(0, -128, 1, 1);    // R2 minimum negated
    drive(-128, 1, 1, 1);    // R3
    drive(127, -128, 0, 1);  // R5 mixed add
    drive(-128, -1, 1, 1);   // R5 same-sign sub
    drive(5, 5, 1, 1);       // R6 zero, no borrow
    drive(3, 5, 1, 1);       // R7 borrow
    drive(-1, 1, 0, 1);      // R6 zero + carry
    drive(3, 0, 0, 0);       // R10 hold
    drive(-64, 64, 0, 0);    // R10 hold
    drive(6, 1, 0, 1);       // R9 odd
    drive(2, 1, 0, 1);       // R9 even
    drive(-1, -1, 0, 1);     // R8 sign
    for (int i = 0; i < 40; i++)
      drive((i * 37) % 256 - 128, (i * 91) % 256 - 128, i[0], i[1] | i[2]);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule